// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. It uses a clock enable `tick16` that pulses at sixteen times the bit rate. The line first passes through a short synchronizer. A state machine then finds the start of each character, samples every bit in the middle of its sixteen-tick period and collects data, least significant bit first. After the data bits it takes an optional parity bit and checks the first stop bit.

The character is placed right-justified into an output holding register and a data-available flag is raised. Framing, parity and overrun flags are updated with every character. The consumer clears data-available by pulling `clear_avail_n` low.

The format controls are the word length (5 to 8 bits) and parity (off, odd or even). They must stay stable while a character is being received.

The state machine has five states:

| State | Transition out |
|---|---|
| `RX_IDLE` | Goes to `RX_START` on a tick where the synchronized line is low and was high on the previous tick. |
| `RX_START` | Goes to `RX_DATA` if the line is still low at the start-bit midpoint. Goes back to `RX_IDLE` if the line is high there (noise). |
| `RX_DATA` | Shifts one bit every 16 ticks. After the last data bit it goes to `RX_PARITY` when parity is on, or to `RX_STOP` when parity is off. |
| `RX_PARITY` | Captures the parity bit, then goes to `RX_STOP`. |
| `RX_STOP` | Samples the stop bit, transfers the character to the holding register and goes to `RX_IDLE`. |

Top module: `async_rx`

## Requirements
- R1: A character starts only on a high-to-low transition of the synchronized line seen between two ticks. A line held low after a character does not start another one.
- R2: The start bit is sampled again 8 ticks after the edge is seen. If the line is high at that point, the receiver returns to idle and no character is delivered.
- R3: Data bits are sampled every 16 ticks, least significant bit first. `word_len` 0,1,2,3 selects 5,6,7,8 bits. `rx_byte` holds the character right-justified, and the bits above the word length read 0.
- R4: `avail` goes to 1 in the cycle after a character is transferred. A low `clear_avail_n` clears it. When a transfer and a clear happen in the same cycle, the transfer wins.
- R5: When `parity_off` is 0, one parity bit follows the data bits. `parity_even` set to 1 selects even parity and set to 0 selects odd parity.
- R6: A newly transferred character always replaces the old one. `overrun` is set to 1 if `avail` was still 1 at the transfer and to 0 otherwise.
- R7: `frame_err` is set to 1 when the first stop bit is sampled low and to 0 when it is sampled high. It is updated with every character.
- R8: `parity_err` is set to 1 when the data bits and the parity bit do not match the selected parity, and to 0 when they do. It is always 0 for a character received with parity off.
- R9: After reset, `avail`, `overrun`, `frame_err`, `parity_err` and `rx_byte` are all 0.
- R10: Only the first stop bit is checked. A start edge that comes right after one stop bit begins the next character, so characters sent back to back are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rx_line | input | 1 | Serial input; idle (mark) is high |
| word_len | input | 2 | Number of data bits minus 5 |
| parity_off | input | 1 | 1: no parity bit is expected |
| parity_even | input | 1 | 1: even parity; 0: odd parity |
| clear_avail_n | input | 1 | Clears `avail` when low |
| rx_byte | output | 8 | Received character, right-justified |
| avail | output | 1 | A character is waiting in the holding register |
| overrun | output | 1 | The last transfer replaced an unread character |
| frame_err | output | 1 | The last character had a low stop bit |
| parity_err | output | 1 | The last character failed the parity check |

## Verification
The bench sends characters in four formats and compares every output against a reference model on every clock:

- 8 bits with no parity.
- 7 bits with even parity.
- 5 bits with odd parity and a wrong parity bit.
- 6 bits with a low stop bit.

These patterns tell apart errors in bit order, justification, masking, parity sense, and whether the stop bit is judged in parity and no-parity modes.

Three further patterns check the state machine's transitions:

- Characters sent back to back with one stop bit show whether the receiver rearms right after the first stop sample.
- A low glitch shorter than half a bit shows whether start validation works.
- A long break shows that only a falling edge starts a character.

Unread characters check how the overrun flag is set and cleared.

// File: rtl/rx_pkg.sv
package rx_pkg;
    localparam int RX_BYTE_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES <= 1) begin : g_single
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b1;
                else        q <= din;
            end
            assign dout = q;
        end else begin : g_chain
            logic [STAGES-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], din};
            end
            assign dout = q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rx_fsm.sv
module rx_fsm
    import rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line,
    input  logic [2:0]           last_idx,
    input  logic                 parity_on,
    output logic                 load,
    output logic [RX_BYTE_W-1:0] shift_word,
    output logic                 par_bit,
    output logic                 stop_ok
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] MID_T  = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_T = CNT_W'(OVERSAMPLE - 1);

    rx_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       bit_idx;
    logic             prev_line;
    logic             cnt_clr, shift_en, par_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // next state and strobes
    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        shift_en = 1'b0;
        par_en   = 1'b0;
        load     = 1'b0;
        unique case (state)
            RX_IDLE: begin
                if (tick && prev_line && !line) begin
                    state_nx = RX_START;
                    cnt_clr  = 1'b1;
                end
            end
            RX_START: begin
                if (tick && cnt == MID_T) begin
                    cnt_clr  = 1'b1;
                    state_nx = line ? RX_IDLE : RX_DATA;
                end
            end
            RX_DATA: begin
                if (tick && cnt == LAST_T) begin
                    cnt_clr  = 1'b1;
                    shift_en = 1'b1;
                    if (bit_idx == last_idx)
                        state_nx = parity_on ? RX_PARITY : RX_STOP;
                end
            end
            RX_PARITY: begin
                if (tick && cnt == LAST_T) begin
                    cnt_clr  = 1'b1;
                    par_en   = 1'b1;
                    state_nx = RX_STOP;
                end
            end
            RX_STOP: begin
                if (tick && cnt == LAST_T) begin
                    cnt_clr  = 1'b1;
                    load     = 1'b1;
                    state_nx = RX_IDLE;
                end
            end
            default: state_nx = RX_IDLE;
        endcase
    end

    // datapath: tick counter, bit index, shift register, parity capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            bit_idx    <= '0;
            prev_line  <= 1'b1;
            shift_word <= '0;
            par_bit    <= 1'b0;
        end else begin
            if (tick) begin
                cnt       <= cnt_clr ? '0 : cnt + 1'b1;
                prev_line <= line;
            end
            if (state != RX_DATA) bit_idx <= '0;
            else if (shift_en)    bit_idx <= bit_idx + 1'b1;
            if (shift_en) shift_word <= {line, shift_word[RX_BYTE_W-1:1]};
            if (par_en)   par_bit    <= line;
        end
    end

    assign stop_ok = line;
endmodule

// File: rtl/rx_hold.sv
module rx_hold
    import rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [RX_BYTE_W-1:0] shift_word,
    input  logic [1:0]           word_len,
    input  logic                 par_bit,
    input  logic                 parity_on,
    input  logic                 parity_even,
    input  logic                 stop_ok,
    input  logic                 clear_n,
    output logic [RX_BYTE_W-1:0] data_q,
    output logic                 avail_q,
    output logic                 ovr_q,
    output logic                 fe_q,
    output logic                 pe_q
);
    logic [2:0]           drop;
    logic [RX_BYTE_W-1:0] justified;
    logic                 odd_sum;

    always_comb begin
        drop      = 3'd3 - {1'b0, word_len};
        justified = shift_word >> drop;
        odd_sum   = (^justified) ^ par_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            avail_q <= 1'b0;
            ovr_q   <= 1'b0;
            fe_q    <= 1'b0;
            pe_q    <= 1'b0;
        end else if (load) begin
            data_q  <= justified;
            avail_q <= 1'b1;
            ovr_q   <= avail_q;
            fe_q    <= !stop_ok;
            pe_q    <= parity_on && (odd_sum ^ !parity_even);
        end else if (!clear_n) begin
            avail_q <= 1'b0;
        end
    end
endmodule

// File: rtl/async_rx.sv
module async_rx
    import rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 rx_line,
    input  logic [1:0]           word_len,
    input  logic                 parity_off,
    input  logic                 parity_even,
    input  logic                 clear_avail_n,
    output logic [RX_BYTE_W-1:0] rx_byte,
    output logic                 avail,
    output logic                 overrun,
    output logic                 frame_err,
    output logic                 parity_err
);
    logic                 line_s;
    logic                 load;
    logic [RX_BYTE_W-1:0] shift_word;
    logic                 par_bit;
    logic                 stop_ok;
    logic [2:0]           last_idx;

    assign last_idx = {1'b0, word_len} + 3'd4;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    rx_fsm #(.OVERSAMPLE(OVERSAMPLE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .line      (line_s),
        .last_idx  (last_idx),
        .parity_on (!parity_off),
        .load      (load),
        .shift_word(shift_word),
        .par_bit   (par_bit),
        .stop_ok   (stop_ok)
    );

    rx_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .shift_word (shift_word),
        .word_len   (word_len),
        .par_bit    (par_bit),
        .parity_on  (!parity_off),
        .parity_even(parity_even),
        .stop_ok    (stop_ok),
        .clear_n    (clear_avail_n),
        .data_q     (rx_byte),
        .avail_q    (avail),
        .ovr_q      (overrun),
        .fe_q       (frame_err),
        .pe_q       (parity_err)
    );
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       load,
    input logic       stop_ok,
    input logic       clear_avail_n,
    input logic       parity_off,
    input logic [1:0] word_len,
    input logic [7:0] rx_byte,
    input logic       avail,
    input logic       overrun,
    input logic       frame_err,
    input logic       parity_err
);
    // R4
    avail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> avail);

    // R4
    avail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_avail_n && !load) |=> !avail);

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && avail) |=> overrun);

    // R6
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !avail) |=> !overrun);

    // R7
    frame_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (frame_err == !$past(stop_ok)));

    // R8
    parity_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && parity_off) |=> !parity_err);

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word_len == 2'd0) |=> (rx_byte[7:5] == 3'b000));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rx_byte));
endmodule

bind async_rx async_rx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .stop_ok      (stop_ok),
    .clear_avail_n(clear_avail_n),
    .parity_off   (parity_off),
    .word_len     (word_len),
    .rx_byte      (rx_byte),
    .avail        (avail),
    .overrun      (overrun),
    .frame_err    (frame_err),
    .parity_err   (parity_err)
);

// File: tb/sim_async_rx.sv
`timescale 1ns/1ps
module sim_async_rx;
    localparam int BIT_CLKS = 64;   // 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] word_len = 2'd3;
    logic       parity_off = 1'b1;
    logic       parity_even = 1'b0;
    logic       clear_avail_n = 1'b1;
    logic [7:0] rx_byte;
    logic       avail, overrun, frame_err, parity_err;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int div = 0;

    always #5 clk = ~clk;

    async_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
        .word_len(word_len), .parity_off(parity_off), .parity_even(parity_even),
        .clear_avail_n(clear_avail_n), .rx_byte(rx_byte), .avail(avail),
        .overrun(overrun), .frame_err(frame_err), .parity_err(parity_err)
    );

    always @(negedge clk) begin
        tick16 <= (div == 0);
        div    <= (div == 3) ? 0 : div + 1;
    end

    // behavioural reference model
    bit       lq[$];
    int       ph, mc, nb;
    bit       mprev, pb, stp, seen, ld;
    bit [7:0] sh, m_byte;
    bit       m_av, m_ovr, m_fe, m_pe;

    always @(posedge clk) begin
        if (!rst_n) begin
            lq = {};
            lq.push_back(1'b1);
            lq.push_back(1'b1);
            ph = 0; mc = 0; nb = 0; mprev = 1; pb = 0; stp = 1; sh = 0;
            m_byte = 0; m_av = 0; m_ovr = 0; m_fe = 0; m_pe = 0;
        end else begin
            int len;
            bit x;
            len = int'(word_len) + 5;
            seen = lq[0];
            void'(lq.pop_front());
            lq.push_back(rx_line);
            ld = 0;
            if (tick16) begin
                case (ph)
                    0: if (mprev && !seen) begin ph = 1; mc = 0; end
                    1: if (mc == 7) begin ph = seen ? 0 : 2; mc = 0; nb = 0; end else mc++;
                    2: if (mc == 15) begin
                           sh = {seen, sh[7:1]}; mc = 0;
                           if (nb == len - 1) ph = parity_off ? 4 : 3; else nb++;
                       end else mc++;
                    3: if (mc == 15) begin pb = seen; mc = 0; ph = 4; end else mc++;
                    default: if (mc == 15) begin ld = 1; stp = seen; ph = 0; mc = 0; end else mc++;
                endcase
                mprev = seen;
            end
            if (ld) begin
                m_byte = sh >> (8 - len);
                x      = (^m_byte) ^ pb;
                m_ovr  = m_av;
                m_av   = 1;
                m_fe   = !stp;
                m_pe   = !parity_off && (x ^ !parity_even);
            end else if (!clear_avail_n) m_av = 0;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (rx_byte !== m_byte || avail !== m_av || overrun !== m_ovr ||
                frame_err !== m_fe || parity_err !== m_pe) begin
                n_bad++;
                $display("FAIL R3/R4/R6/R7/R8 model @%0d: byte %h/%h av %b/%b ov %b/%b fe %b/%b pe %b/%b",
                         cyc, rx_byte, m_byte, avail, m_av, overrun, m_ovr,
                         frame_err, m_fe, parity_err, m_pe);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold_line(input bit v, input int clks);
        rx_line = v;
        repeat (clks) @(negedge clk);
    endtask

    // one character: start, len data bits LSB first, optional parity, one stop
    task automatic send(input bit [7:0] d, input int len, input bit with_par,
                        input bit par_v, input bit stop_v);
        hold_line(1'b0, BIT_CLKS);
        for (int i = 0; i < len; i++) hold_line(d[i], BIT_CLKS);
        if (with_par) hold_line(par_v, BIT_CLKS);
        hold_line(stop_v, BIT_CLKS);
    endtask

    function automatic bit good_par(input bit [7:0] d, input int len, input bit even);
        bit s = 0;
        for (int i = 0; i < len; i++) s ^= d[i];
        return even ? s : !s;
    endfunction

    task automatic clear_avail();
        clear_avail_n = 1'b0;
        @(negedge clk);
        clear_avail_n = 1'b1;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk("R9 avail", avail, 0);
        chk("R9 byte", rx_byte, 0);
        chk("R9 flags", {overrun, frame_err, parity_err}, 0);
        rst_n = 1'b1;
        hold_line(1'b1, 3 * BIT_CLKS);

        // R3 R4: 8 bits no parity
        word_len = 2'd3; parity_off = 1;
        send(8'hA5, 8, 0, 0, 1);
        chk("R3 byte 8N", rx_byte, 8'hA5);
        chk("R4 avail set", avail, 1);
        clear_avail();
        chk("R4 avail cleared", avail, 0);

        // R5 R8: 7 bits even, correct parity
        word_len = 2'd2; parity_off = 0; parity_even = 1;
        send(8'h5A, 7, 1, good_par(8'h5A, 7, 1), 1);
        chk("R3 byte 7E", rx_byte, 8'h5A);
        chk("R5 parity ok even", parity_err, 0);
        clear_avail();

        // R8: 5 bits odd, wrong parity
        word_len = 2'd0; parity_even = 0;
        send(8'hFF, 5, 1, !good_par(8'h1F, 5, 0), 1);
        chk("R3 upper bits zero", rx_byte, 8'h1F);
        chk("R8 parity error", parity_err, 1);
        clear_avail();

        // R7: 6 bits, no parity, low stop bit
        word_len = 2'd1; parity_off = 1;
        send(8'h2C, 6, 0, 0, 0);
        hold_line(1'b1, BIT_CLKS);
        chk("R7 framing error", frame_err, 1);
        chk("R8 no-parity forces 0", parity_err, 0);
        chk("R3 byte 6N", rx_byte, 8'h2C);

        // R6: unread character replaced
        send(8'h33, 6, 0, 0, 1);
        chk("R6 overrun set", overrun, 1);
        chk("R6 new byte kept", rx_byte, 8'h33);
        chk("R7 framing cleared", frame_err, 0);
        clear_avail();
        send(8'h14, 6, 0, 0, 1);
        chk("R6 overrun cleared", overrun, 0);
        clear_avail();

        // R10: back-to-back, one stop bit each
        word_len = 2'd3;
        send(8'h81, 8, 0, 0, 1);
        chk("R10 first", rx_byte, 8'h81);
        send(8'h7E, 8, 0, 0, 1);
        chk("R10 second", rx_byte, 8'h7E);
        send(8'hC3, 8, 0, 0, 1);
        chk("R10 third", rx_byte, 8'hC3);
        clear_avail();
        hold_line(1'b1, 2 * BIT_CLKS);

        // R2: short low glitch rejected
        hold_line(1'b0, 12);
        hold_line(1'b1, 20 * BIT_CLKS);
        chk("R2 glitch ignored", avail, 0);
        chk("R2 byte unchanged", rx_byte, 8'hC3);

        // R1: long break gives one character only
        hold_line(1'b0, 12 * BIT_CLKS);
        chk("R1 break char", avail, 1);
        chk("R1 break framing", frame_err, 1);
        clear_avail();
        hold_line(1'b0, 20 * BIT_CLKS);
        chk("R1 no restart while low", avail, 0);
        hold_line(1'b1, 3 * BIT_CLKS);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule